// File: doc/BRIEF.md
# Reloading Interval Down-Counter

This block is a periodic event timer. A single configuration word sets a 13-bit period, picks what advances the count, and gates the counter. The count can advance on every second system clock or on each rising edge of an external tick input. Driving the tick input from another divider's output cascades the two into one longer timer. Each time the count runs out, the block emits a single-cycle interrupt pulse and reloads the programmed period, so pulses repeat at a fixed interval without any further writes.

A period of zero is a deliberate idle setting. Writing zero while the counter runs stops further pulses, which turns the timer into a one-shot. Clearing the enable bit shuts the counter down until the next reset; later writes cannot turn it back on. The configuration write is a plain one-cycle strobe with no handshake. The interrupt is a one-cycle level pulse meant for an interrupt controller outside this block.

Top module: `tmr13_timer`

## Requirements
- R1: After reset the period is 0, counting is stopped, the source is the halved system clock and the enable bit is 1; `irq_pulse` stays low until a configuration write starts the counter.
- R2: A write with `cfg_we` high stores the word: bits 12..0 are the period, bit 13 the source (0 = halved system clock, 1 = external tick), bit 14 the run bit and bit 15 the enable bit. The write also loads the period into the counter.
- R3: With source 0, enable 1, run 1 and period N > 0, `irq_pulse` is high in the cycle that follows clock edge 2N, 4N, 6N and so on after the writing edge. Writing 0xC008 gives one pulse every 16 system clocks.
- R4: With source 1, the count advances once per rising edge of `ext_tick`, however long the input stays high. The pulse follows the clock edge that sees the N-th, 2N-th, and each later multiple-of-N rising edge counted after the write.
- R5: A period of 0 never produces a pulse. Writing 0 while a count is under way cancels the pending pulse.
- R6: While the run bit is 0, the count holds and no pulse appears.
- R7: Once a write clears the enable bit, no pulse appears until reset, even if later writes set the bit again. After reset the counter works normally.
- R8: Each pulse lasts exactly one system clock.
- R9: Every write restarts the count and the clock-halving phase, so the next pulse is timed from the latest write.
- R10: The inactive source has no effect: `ext_tick` activity is ignored while source 0 is selected, and the halved clock is ignored while source 1 is selected.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_wdata | input | 16 | Configuration word (period, source, run, enable) |
| ext_tick | input | 1 | External cascade tick, synchronous to clk |
| irq_pulse | output | 1 | One-cycle interrupt pulse when the count runs out |

## Verification
The bench targets the reload boundary. A design that reloads one tick late would stretch the 0xC008 interval to 18 cycles instead of 16. An external tick held high for several cycles must count once; a level-sensitive design would race through the period. A zero period, or a zero written in the middle of a count, must stay silent; a counter that wraps below zero would fire after 8192 ticks. The bench also sets the enable bit again after clearing it, where a non-sticky enable would resume pulsing, and rewrites mid-count, where a design that keeps the old count or halving phase would fire early.

// File: rtl/tmr13_pkg.sv
package tmr13_pkg;
  // count advance source
  typedef enum logic {
    SRC_HALF = 1'b0,
    SRC_EXT  = 1'b1
  } tick_src_e;
endpackage

// File: rtl/tmr13_cfg.sv
module tmr13_cfg #(
  parameter int CNT_W = 13,
  localparam int CFG_W = CNT_W + 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [CFG_W-1:0]       wdata,
  output logic [CNT_W-1:0]       reload,
  output tmr13_pkg::tick_src_e   src,
  output logic                   run,
  output logic                   en
);
  localparam int SRC_BIT = CNT_W;
  localparam int RUN_BIT = CNT_W + 1;
  localparam int EN_BIT  = CNT_W + 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
      src    <= tmr13_pkg::SRC_HALF;
      run    <= 1'b0;
      en     <= 1'b1;
    end else if (we) begin
      reload <= wdata[CNT_W-1:0];
      src    <= tmr13_pkg::tick_src_e'(wdata[SRC_BIT]);
      run    <= wdata[RUN_BIT];
      en     <= en & wdata[EN_BIT];   // once low, stays low until reset
    end
  end
endmodule

// File: rtl/tmr13_tick.sv
module tmr13_tick (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  tmr13_pkg::tick_src_e src,
  input  logic                 ext_tick,
  output logic                 tick
);
  logic half_q;
  logic ext_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q     <= 1'b0;
      ext_prev_q <= 1'b0;
    end else begin
      half_q     <= restart ? 1'b0 : ~half_q;
      ext_prev_q <= ext_tick;
    end
  end

  always_comb begin
    if (src == tmr13_pkg::SRC_EXT) tick = ext_tick & ~ext_prev_q;
    else                           tick = half_q;
  end
endmodule

// File: rtl/tmr13_core.sv
module tmr13_core #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (active && tick) begin
        if (cnt <= ONE) begin
          // last step of a period: reload at once, fire only from 1
          cnt <= reload;
          irq <= (cnt == ONE);
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end
endmodule

// File: rtl/tmr13_timer.sv
module tmr13_timer #(
  parameter int CNT_W = 13,
  localparam int CFG_W = CNT_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ext_tick,
  output logic             irq_pulse
);
  logic [CNT_W-1:0]     cfg_reload;
  tmr13_pkg::tick_src_e cfg_src;
  logic                 cfg_run;
  logic                 cfg_en;
  logic                 tick;
  logic [CNT_W-1:0]     cnt_q;

  tmr13_cfg #(.CNT_W(CNT_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .reload(cfg_reload), .src(cfg_src), .run(cfg_run), .en(cfg_en)
  );

  tmr13_tick tick_i (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .src(cfg_src),
    .ext_tick(ext_tick), .tick(tick)
  );

  tmr13_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n), .load(cfg_we),
    .load_val(cfg_wdata[CNT_W-1:0]), .active(cfg_en & cfg_run),
    .tick(tick), .reload(cfg_reload), .cnt(cnt_q), .irq(irq_pulse)
  );
endmodule

// File: rtl/tmr13_chk.sv
module tmr13_chk #(
  parameter int CNT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             we,
  input logic [CNT_W-1:0] wval,
  input logic             irq,
  input logic             en,
  input logic             run,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] cnt
);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  // R7
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !en);
  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !irq);
  // R5
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (reload == '0) |-> !irq);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!run && !we) |=> $stable(cnt));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n) we |=> (cnt == $past(wval)));
endmodule

bind tmr13_timer tmr13_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .we(cfg_we), .wval(cfg_wdata[CNT_W-1:0]),
  .irq(irq_pulse), .en(cfg_en), .run(cfg_run), .reload(cfg_reload), .cnt(cnt_q)
);

// File: tb/tmr13_timer_tb_top.sv
`timescale 1ns/1ps
module tmr13_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        ext_tick = 1'b0;
  logic        irq_pulse;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tmr13_timer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ext_tick(ext_tick), .irq_pulse(irq_pulse)
  );

  function automatic bit sys_expect(int n, int k);
    return (n != 0) && (k % (2 * n) == 0);
  endfunction

  task automatic report(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // halved-clock source: compare each cycle, optionally toggling ext_tick
  task automatic run_sys(int n, int cycles, bit noise, string req);
    bit ok = 1;
    int act = 0, exp = 0;
    for (int k = 1; k <= cycles; k++) begin
      @(negedge clk);
      if (ok && (irq_pulse !== sys_expect(n, k))) begin
        ok = 0; act = irq_pulse; exp = sys_expect(n, k);
        $display("  mismatch at cycle %0d of period %0d", k, n);
      end
      if (noise) ext_tick = 1'($urandom_range(0, 1));
    end
    ext_tick = 1'b0;
    report(ok, req, act, exp);
  endtask

  // external source: random levels, expectation from counted rising edges
  task automatic run_ext(int n, int cycles, string req);
    bit ok = 1, prev = 0, exp_next = 0;
    int act = 0, exp = 0, rises = 0;
    for (int k = 1; k <= cycles; k++) begin
      bit v, rise;
      @(negedge clk);
      if (ok && (irq_pulse !== exp_next)) begin
        ok = 0; act = irq_pulse; exp = exp_next;
        $display("  mismatch at cycle %0d after %0d edges", k, rises);
      end
      v = 1'($urandom_range(0, 2) != 0);
      rise = v & ~prev;
      if (rise) rises++;
      exp_next = rise && (n != 0) && (rises % n == 0);
      prev = v;
      ext_tick = v;
    end
    @(negedge clk);
    if (ok && (irq_pulse !== exp_next)) begin
      ok = 0; act = irq_pulse; exp = exp_next;
    end
    ext_tick = 1'b0;
    report(ok, req, act, exp);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    @(negedge clk);
    report(irq_pulse === 1'b0, "R1 reset irq", irq_pulse, 0);
    run_sys(0, 60, 1'b1, "R1 idle after reset");
    // R3: 0xC008 -> every 16 cycles
    wr(16'hC008);
    run_sys(8, 64, 1'b0, "R3 C008 period 16");
    // R2 R3: period of 1 fires every second cycle
    wr(16'hC001);
    run_sys(1, 20, 1'b0, "R2 R3 period 1");
    // R3 R10 R8: random periods with ext noise in halved-clock mode
    for (int i = 0; i < 6; i++) begin
      int n = $urandom_range(1, 60);
      wr(16'hC000 | 16'(n));
      run_sys(n, 6 * n, 1'b1, "R3 R8 R10 random sys period");
    end
    // R4 R8: external source with held-high pulses
    for (int i = 0; i < 6; i++) begin
      int n = $urandom_range(1, 12);
      wr(16'hE000 | 16'(n));
      run_ext(n, 150, "R4 R8 external edges");
    end
    // R10: external source ignores the halved clock
    wr(16'hE002);
    run_sys(0, 50, 1'b0, "R10 ext mode quiet without edges");
    // R5: zero period never fires
    wr(16'hC000);
    run_sys(0, 100, 1'b0, "R5 zero period");
    // R5: zero written mid-count cancels the pulse
    wr(16'hC004);
    run_sys(4, 5, 1'b0, "R5 before cancel");
    wr(16'hC000);
    run_sys(0, 60, 1'b0, "R5 single pass cancel");
    // R6: run bit clear holds the count
    wr(16'h8005);
    run_sys(0, 50, 1'b0, "R6 run clear");
    // R9: rewrite mid-count restarts timing
    wr(16'hC005);
    run_sys(5, 7, 1'b0, "R9 first partial");
    wr(16'hC005);
    run_sys(5, 30, 1'b0, "R9 restart");
    wr(16'hC003);
    @(negedge clk);
    wr(16'hC003);
    run_sys(3, 18, 1'b0, "R9 odd-phase restart");
    // R7: disable is sticky
    wr(16'h4005);
    run_sys(0, 40, 1'b0, "R7 disabled");
    wr(16'hC003);
    run_sys(0, 40, 1'b0, "R7 re-enable ignored");
    wr(16'hE001);
    run_ext(0, 60, "R7 ext while disabled");
    // R7 R1: reset restores enable
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    report(irq_pulse === 1'b0, "R1 reset irq again", irq_pulse, 0);
    wr(16'hC003);
    run_sys(3, 30, 1'b0, "R7 works after reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule